// File: doc/BRIEF.md
# Delayed Parity Checker with Error Stretch

This block guards a registered address/command path with an odd-parity check. The controller sends each data word on one clock edge and its parity bit one edge later. The checker first registers the word, together with a qualifier taken from two active-low chip selects. On the next edge it combines the registered word with the late parity bit. If the total number of ones is even, it records a mismatch. One edge after that, a small state machine pulls an active-low error flag down and keeps it low for two cycles.

A word captured while both chip selects are high is not checked. Such a word neither starts nor cuts short an error indication. An asynchronous active-low reset empties the pipeline and forces the flag high at once.

The stretch machine has three states. ST_IDLE holds the flag high. ST_HOLD_A is the first low cycle and ST_HOLD_B is the second. The transitions are:
- `idle_to_hold_a`: from ST_IDLE on a mismatch.
- `hold_a_to_hold_b`: from ST_HOLD_A when there is no mismatch.
- `hold_b_to_idle`: from ST_HOLD_B when there is no mismatch.
- `restart`: from ST_HOLD_A or ST_HOLD_B back to ST_HOLD_A on a mismatch.
- `idle_stay`: ST_IDLE stays put when there is no mismatch.

Top module: `rcp_parity_guard`

## Requirements
- R1: A word is in error when the count of ones across its 22 data bits plus its parity bit is even. An odd count is accepted.
- R2: The parity bit for the word captured at clock edge k is the value on `par_in` at edge k+1.
- R3: For a word in error captured at edge k, `err_n` goes low right after edge k+2, the parity edge being k+1.
- R4: After an isolated error, `err_n` stays low for exactly two clock cycles and then returns high.
- R5: A new error found while the flag is low restarts the two-cycle hold, counted from the new error.
- R6: A word captured with `cs0_n` and `cs1_n` both high is never flagged. A word with either chip select low is checked.
- R7: While `rst_n` is low, `err_n` is high at once, without waiting for a clock edge. Words already in the pipeline when reset is taken are discarded.
- R8: `err_n` is active low: it stays high whenever no error lies within its two-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| data_in | input | 22 | Gated address/command data lanes |
| par_in | input | 1 | Parity bit, one cycle after its word |
| err_n | output | 1 | Active-low error flag, held two cycles |

## Verification
The in-line assertions check the following on every cycle:
- a recorded mismatch pulls the flag low on the next edge;
- a falling flag stays low for a second cycle;
- a mismatch during the hold returns the machine to its first hold state;
- a release from the second hold state raises the flag;
- a masked word never produces a mismatch;
- the flag is high under reset.

Three things only the bench scenarios can show. The first is that parity is counted over the right bits, paired with the parity bit one cycle later. The second is the exact two-edge latency from the parity edge to the flag. The third is that a mismatch already in the pipeline is discarded by a mid-run reset. The bench shows these by predicting the flag arithmetically from the stimulus, cycle by cycle.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    // Stretch machine states: flag high in ST_IDLE, low in both hold states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD_A = 2'd1,
        ST_HOLD_B = 2'd2
    } stretch_state_e;

    localparam int unsigned CS_COUNT = 2;

endpackage

// File: rtl/rcp_capture.sv
module rcp_capture #(
    parameter int unsigned DATA_W = 22,
    parameter int unsigned CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CS_W-1:0]   cs_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q
);

    logic any_sel;

    // A word counts when at least one chip select is low
    always_comb begin
        any_sel = 1'b0;
        for (int i = 0; i < int'(CS_W); i++) begin
            if (!cs_n[i]) any_sel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            data_q  <= data_in;
            valid_q <= any_sel;
        end
    end

endmodule

// File: rtl/rcp_parity_cmp.sv
module rcp_parity_cmp #(
    parameter int unsigned DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_q,
    input  logic              valid_q,
    input  logic              par_in,
    output logic              mismatch_q
);

    logic odd_total;

    // XOR across the registered word and the parity bit: 1 means odd count
    always_comb begin
        odd_total = par_in;
        for (int i = 0; i < int'(DATA_W); i++) begin
            odd_total = odd_total ^ data_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mismatch_q <= 1'b0;
        else        mismatch_q <= valid_q & ~odd_total;
    end

endmodule

// File: rtl/rcp_stretch_fsm.sv
module rcp_stretch_fsm
    import rcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    output logic flag_n
);

    stretch_state_e state, state_nx;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = mismatch ? ST_HOLD_A : ST_IDLE;    // idle_to_hold_a / idle_stay
            ST_HOLD_A: state_nx = mismatch ? ST_HOLD_A : ST_HOLD_B;  // restart / hold_a_to_hold_b
            ST_HOLD_B: state_nx = mismatch ? ST_HOLD_A : ST_IDLE;    // restart / hold_b_to_idle
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output decode
    always_comb begin
        flag_n = 1'b1;
        unique case (state)
            ST_IDLE:   flag_n = 1'b1;
            ST_HOLD_A: flag_n = 1'b0;
            ST_HOLD_B: flag_n = 1'b0;
            default:   flag_n = 1'b1;
        endcase
    end

    AST_MISMATCH_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> !flag_n);  // R3
    AST_LOW_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_n) |=> !flag_n);  // R4
    AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_n && mismatch) |=> (state == ST_HOLD_A));  // R5
    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD_B && !mismatch) |=> flag_n);  // R8

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_HIGH: assert (flag_n);  // R7
    end

endmodule

// File: rtl/rcp_parity_guard.sv
module rcp_parity_guard
    import rcp_pkg::*;
#(
    parameter int unsigned DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    output logic              err_n
);

    logic [DATA_W-1:0] word_q;
    logic              word_valid;
    logic              mismatch_q;

    rcp_capture #(
        .DATA_W (DATA_W),
        .CS_W   (CS_COUNT)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    ({cs1_n, cs0_n}),
        .data_in (data_in),
        .data_q  (word_q),
        .valid_q (word_valid)
    );

    rcp_parity_cmp #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_q     (word_q),
        .valid_q    (word_valid),
        .par_in     (par_in),
        .mismatch_q (mismatch_q)
    );

    rcp_stretch_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (mismatch_q),
        .flag_n   (err_n)
    );

    AST_MASKED_NO_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> !mismatch_q);  // R6

endmodule

// File: tb/sim_rcp_parity_guard.sv
`timescale 1ns/1ps
module sim_rcp_parity_guard;

    localparam int DW = 22;
    localparam int N  = 480;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs0_n = 1'b1;
    logic          cs1_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          par_in = 1'b0;
    logic          err_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] w_data [N];
    logic [1:0]    w_cs   [N];
    bit            w_fault[N];
    logic          w_par  [N];
    string         w_tag  [N];

    rcp_parity_guard #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .data_in(data_in), .par_in(par_in), .err_n(err_n)
    );

    always #10 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: err_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // A word is flagged when it was checked (a chip select low, R6) and its parity was faulted
    function automatic bit bad(input int w);
        if (w < 0 || w >= N - 1) return 1'b0;
        return (w_cs[w] != 2'b11) && w_fault[w];
    endfunction

    // Flag value after edge m: low if word m-2 or m-3 was bad (R3, R4, R5)
    function automatic logic exp_flag(input int m);
        return !(bad(m - 2) || bad(m - 3));
    endfunction

    initial begin
        // Build the stimulus
        for (int c = 0; c < N; c++) begin
            w_cs[c]    = 2'b00;
            w_fault[c] = 1'b0;
            if (c < 40) begin                       // R1: walking ones, correct parity
                w_data[c] = DW'(1) << (c % DW);
                w_cs[c]   = (c % 2) ? 2'b01 : 2'b10;
                w_tag[c]  = "R1";
            end else if (c < 120) begin             // R3/R4: isolated faults
                w_data[c]  = DW'($urandom);
                w_fault[c] = (c % 8 == 0);
                w_tag[c]   = "R4";
            end else if (c < 200) begin             // R5: faults during the hold
                w_data[c]  = DW'($urandom);
                w_fault[c] = (c % 12 == 0) || (c % 12 == 1) || (c % 12 == 6) || (c % 12 == 8);
                w_tag[c]   = "R5";
            end else if (c < 280) begin             // R6: masked faults
                w_data[c]  = DW'($urandom);
                w_cs[c]    = (c % 4 == 3) ? 2'b10 : ((c % 4 == 1) ? 2'b01 : 2'b11);
                w_fault[c] = (c % 2 == 1) || (c % 4 == 2);
                w_tag[c]   = "R6";
            end else begin                          // R2: random, late parity pairing
                w_data[c]  = DW'($urandom);
                w_cs[c]    = 2'($urandom);
                w_fault[c] = ($urandom % 5 == 0);
                w_tag[c]   = "R2";
            end
        end
        for (int c = 0; c < N; c++) begin
            w_par[c] = (c == 0) ? 1'b0 : ((~^w_data[c-1]) ^ w_fault[c-1]);
        end

        // Reset state
        repeat (3) @(negedge clk);
        check(err_n, 1'b1, "R7");
        check(err_n, 1'b1, "R8");

        // Main sweep: release reset, first rising edge is edge 0
        for (int c = 0; c < N; c++) begin
            @(negedge clk);
            rst_n = 1'b1;
            if (c >= 1) check(err_n, exp_flag(c - 1), w_tag[c-1]);
            data_in = w_data[c];
            {cs1_n, cs0_n} = w_cs[c];
            par_in = w_par[c];
        end
        @(negedge clk);
        check(err_n, exp_flag(N - 1), w_tag[N-1]);

        // R7: reset while the flag is low and another error is in the pipeline
        cs0_n = 1'b0; cs1_n = 1'b1;
        data_in = DW'(3); par_in = 1'b0;             // word A, any parity here
        @(negedge clk);
        data_in = DW'(1); par_in = 1'b0;             // A parity: even total -> error; word B
        @(negedge clk);
        par_in = 1'b1;                               // B parity: even total -> error
        cs0_n = 1'b1;
        @(negedge clk);
        check(err_n, 1'b0, "R3");
        rst_n = 1'b0;
        #2;
        check(err_n, 1'b1, "R7");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(err_n, 1'b1, "R7");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule